// File: doc/BRIEF.md
# Interrupt Latency History Buffer

This block keeps a short trace of the interrupts a processor has serviced so that a debugger or a performance monitor can see how long each one waited. Each interrupt source has a raise timestamp slot. Whenever the source's pending bit is newly set, the slot is overwritten with the free-running cycle count. When the processor takes an interrupt, the block writes one record into a circular buffer. The record holds the source number, the cycle of the take and that source's stored raise timestamp. A running total counts every take and every direct software raise.

A read port looks back through the buffer. Read index 0 is the most recent take, index 1 the one before it, and so on. Each read returns the source number and the latency (taken minus raised). For every index above 0 it also returns the gap between the newer neighbour's take time and this entry's take time. Results appear one cycle after the request and hold until the next request. An entry whose take timestamp is zero ends the history: that entry and every older one read back as not valid.

Top module: `irq_latency_trace`

## Requirements
- R1: After reset the total count is 0, every buffer slot and raise timestamp is zero, and a read of any index returns not valid with all data fields zero.
- R2: A raise strobe on source s overwrites that source's raise timestamp with the current cycle count. A later strobe on the same source replaces the earlier stamp.
- R3: A take strobe records the take source number, the current cycle count and the raise timestamp that the source held before this clock edge. A raise of the same source in the same cycle does not affect the record.
- R4: The write pointer advances by one per take and wraps from DEPTH-1 to 0. Once DEPTH takes have happened, each further take overwrites the oldest record.
- R5: The total count rises by one for a take, by one for a software raise, and by two when both happen in one cycle. It wraps modulo 2^CNT_W.
- R6: Read index i returns the record written by the (i+1)-th most recent take, which is slot (write pointer - i - 1) modulo DEPTH.
- R7: A read is valid only if the index is below DEPTH and every record from index 0 up to and including index i has a nonzero take timestamp. Otherwise valid, gap-valid and all data outputs read as zero.
- R8: The latency output equals the take timestamp minus the raise timestamp, modulo 2^TS_W.
- R9: For a valid read with i > 0, gap-valid is 1 and the gap equals the take timestamp at index i-1 minus the one at index i. For i = 0, gap-valid and the gap are 0.
- R10: Read outputs change only on the clock edge that follows a cycle with the read request high. Otherwise they hold their values.
- R11: A take and a read in the same cycle are allowed. The read returns the buffer as it stood before that take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_i | input | TS_W | Free-running cycle count used for all timestamps |
| raise_i | input | NUM_SRC | Per-source strobe: the pending bit was newly set |
| sw_raise_i | input | 1 | Direct software raise, counted in the total |
| take_i | input | 1 | An interrupt is taken this cycle |
| take_src_i | input | SRC_W | Source number of the interrupt being taken |
| rd_req_i | input | 1 | Read request |
| rd_idx_i | input | PTR_W | Look-back index, 0 = newest |
| rd_valid_o | output | 1 | Read result refers to a recorded entry |
| rd_src_o | output | SRC_W | Source number of the entry read |
| rd_latency_o | output | TS_W | Take time minus raise time |
| rd_gap_valid_o | output | 1 | The gap output is meaningful (index above 0) |
| rd_gap_o | output | TS_W | Newer neighbour's take time minus this entry's take time |
| total_o | output | CNT_W | Total of takes and software raises |

## Verification
The bench goes after the walk end in particular. A take recorded at cycle zero must hide itself and every older record. A reader that checked only the selected slot would report stale entries behind it as valid. Wrap-around is covered by reading the oldest slot after more than DEPTH takes. An off-by-one in the slot arithmetic would return the newest record or a neighbour instead of the oldest one. Same-cycle take with read, and take with a raise of the same source, are aimed at designs that forward the new write. Such a design would show a record one step too new, or a latency of zero. A take coinciding with a software raise catches a counter that adds only one.

// File: rtl/ilh_pkg.sv
package ilh_pkg;

  // Slot that holds the record `back` positions behind the newest one.
  function automatic int unsigned ring_slot(input int unsigned wptr,
                                            input int unsigned back,
                                            input int unsigned depth);
    return (wptr + depth - (back % depth) - 1) % depth;
  endfunction

  // Modular difference of two timestamps; caller truncates to its width.
  function automatic logic [63:0] stamp_delta(input logic [63:0] later,
                                              input logic [63:0] earlier);
    return later - earlier;
  endfunction

endpackage

// File: rtl/ilh_stamp_bank.sv
module ilh_stamp_bank #(
  parameter int NUM_SRC = 8,
  parameter int TS_W    = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [TS_W-1:0]                 cycle_i,
  input  logic [NUM_SRC-1:0]              raise_i,
  output logic [NUM_SRC-1:0][TS_W-1:0]    stamps_o
);

  logic [NUM_SRC-1:0][TS_W-1:0] stamp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_q <= '0;
    end else begin
      for (int s = 0; s < NUM_SRC; s++) begin
        if (raise_i[s]) stamp_q[s] <= cycle_i;
      end
    end
  end

  assign stamps_o = stamp_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_stamp_chk
    // R2
    stamp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      raise_i[g] |=> stamps_o[g] == $past(cycle_i));
    // R2
    stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !raise_i[g] |=> $stable(stamps_o[g]));
  end

endmodule

// File: rtl/ilh_ring.sv
module ilh_ring #(
  parameter int NUM_SRC = 8,
  parameter int DEPTH   = 16,
  parameter int TS_W    = 32,
  parameter int SRC_W   = 3,
  parameter int PTR_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take_i,
  input  logic [SRC_W-1:0]              take_src_i,
  input  logic [TS_W-1:0]               cycle_i,
  input  logic [TS_W-1:0]               raised_ts_i,
  output logic [PTR_W-1:0]              wr_ptr_o,
  output logic [DEPTH-1:0][SRC_W-1:0]   src_o,
  output logic [DEPTH-1:0][TS_W-1:0]    taken_o,
  output logic [DEPTH-1:0][TS_W-1:0]    raised_o
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]            wr_ptr_q;
  logic [DEPTH-1:0][SRC_W-1:0] src_q;
  logic [DEPTH-1:0][TS_W-1:0]  taken_q;
  logic [DEPTH-1:0][TS_W-1:0]  raised_q;

  // Named internal events for the checks below.
  logic wr_fire;
  logic wr_last;
  logic wr_wrap;

  assign wr_fire = take_i;
  assign wr_last = (wr_ptr_q == LAST_SLOT);
  assign wr_wrap = wr_fire && wr_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      src_q    <= '0;
      taken_q  <= '0;
      raised_q <= '0;
    end else if (wr_fire) begin
      src_q[wr_ptr_q]    <= take_src_i;
      taken_q[wr_ptr_q]  <= cycle_i;
      raised_q[wr_ptr_q] <= raised_ts_i;
      wr_ptr_q           <= wr_last ? '0 : wr_ptr_q + 1'b1;
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign src_o    = src_q;
  assign taken_o  = taken_q;
  assign raised_o = raised_q;

  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_wrap |=> wr_ptr_o == '0);
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_last) |=> wr_ptr_o == $past(wr_ptr_o) + 1'b1);
  // R4
  ptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(wr_ptr_o));
  // R3
  rec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> taken_o[$past(wr_ptr_o)] == $past(cycle_i)
                && raised_o[$past(wr_ptr_o)] == $past(raised_ts_i)
                && src_o[$past(wr_ptr_o)] == $past(take_src_i));

endmodule

// File: rtl/ilh_reader.sv
module ilh_reader
  import ilh_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TS_W  = 32,
  parameter int SRC_W = 3,
  parameter int PTR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PTR_W-1:0]              wr_ptr_i,
  input  logic [DEPTH-1:0][SRC_W-1:0]   src_i,
  input  logic [DEPTH-1:0][TS_W-1:0]    taken_i,
  input  logic [DEPTH-1:0][TS_W-1:0]    raised_i,
  input  logic                          rd_req_i,
  input  logic [PTR_W-1:0]              rd_idx_i,
  output logic                          rd_valid_o,
  output logic [SRC_W-1:0]              rd_src_o,
  output logic [TS_W-1:0]               rd_latency_o,
  output logic                          rd_gap_valid_o,
  output logic [TS_W-1:0]               rd_gap_o
);

  logic [PTR_W-1:0] slot_of [DEPTH];
  logic [DEPTH-1:0] alive;
  logic [PTR_W-1:0] sel_slot;
  logic [PTR_W-1:0] prev_slot;
  logic             idx_in_range;
  logic             idx_nonzero;
  logic             hit;
  logic [TS_W-1:0]  lat_nxt;
  logic [TS_W-1:0]  gap_nxt;

  // Walk from the newest record back; alive[k] stays high only while every
  // record up to k has a nonzero take timestamp.
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      slot_of[k] = PTR_W'(ring_slot(int'(wr_ptr_i), k, DEPTH));
    end
    alive[0] = (taken_i[slot_of[0]] != '0);
    for (int k = 1; k < DEPTH; k++) begin
      alive[k] = alive[k-1] && (taken_i[slot_of[k]] != '0);
    end
  end

  always_comb begin
    idx_in_range = (int'(rd_idx_i) < DEPTH);
    idx_nonzero  = (rd_idx_i != '0);
    sel_slot     = PTR_W'(ring_slot(int'(wr_ptr_i), int'(rd_idx_i), DEPTH));
    prev_slot    = PTR_W'(ring_slot(int'(wr_ptr_i),
                          idx_nonzero ? int'(rd_idx_i) - 1 : 0, DEPTH));
    hit          = idx_in_range && alive[rd_idx_i];
    lat_nxt      = TS_W'(stamp_delta(64'(taken_i[sel_slot]),
                                     64'(raised_i[sel_slot])));
    gap_nxt      = TS_W'(stamp_delta(64'(taken_i[prev_slot]),
                                     64'(taken_i[sel_slot])));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o     <= 1'b0;
      rd_src_o       <= '0;
      rd_latency_o   <= '0;
      rd_gap_valid_o <= 1'b0;
      rd_gap_o       <= '0;
    end else if (rd_req_i) begin
      rd_valid_o     <= hit;
      rd_src_o       <= hit ? src_i[sel_slot] : '0;
      rd_latency_o   <= hit ? lat_nxt : '0;
      rd_gap_valid_o <= hit && idx_nonzero;
      rd_gap_o       <= (hit && idx_nonzero) ? gap_nxt : '0;
    end
  end

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> $stable(rd_valid_o) && $stable(rd_src_o)
                  && $stable(rd_latency_o) && $stable(rd_gap_valid_o)
                  && $stable(rd_gap_o));
  // R9
  newest_no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && rd_idx_i == '0) |=> !rd_gap_valid_o && rd_gap_o == '0);
  // R9
  gap_implies_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gap_valid_o |-> rd_valid_o);
  // R7
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid_o |-> rd_src_o == '0 && rd_latency_o == '0);

endmodule

// File: rtl/irq_latency_trace.sv
module irq_latency_trace #(
  parameter int NUM_SRC = 8,
  parameter int DEPTH   = 16,
  parameter int TS_W    = 32,
  parameter int CNT_W   = 16,
  parameter int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  parameter int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TS_W-1:0]    cycle_i,
  input  logic [NUM_SRC-1:0] raise_i,
  input  logic               sw_raise_i,
  input  logic               take_i,
  input  logic [SRC_W-1:0]   take_src_i,
  input  logic               rd_req_i,
  input  logic [PTR_W-1:0]   rd_idx_i,
  output logic               rd_valid_o,
  output logic [SRC_W-1:0]   rd_src_o,
  output logic [TS_W-1:0]    rd_latency_o,
  output logic               rd_gap_valid_o,
  output logic [TS_W-1:0]    rd_gap_o,
  output logic [CNT_W-1:0]   total_o
);

  logic [NUM_SRC-1:0][TS_W-1:0] stamps;
  logic [TS_W-1:0]              take_stamp;
  logic [PTR_W-1:0]             wr_ptr;
  logic [DEPTH-1:0][SRC_W-1:0]  ring_src;
  logic [DEPTH-1:0][TS_W-1:0]   ring_taken;
  logic [DEPTH-1:0][TS_W-1:0]   ring_raised;
  logic [CNT_W-1:0]             total_q;

  ilh_stamp_bank #(.NUM_SRC(NUM_SRC), .TS_W(TS_W)) u_stamps (
    .clk      (clk),
    .rst_n    (rst_n),
    .cycle_i  (cycle_i),
    .raise_i  (raise_i),
    .stamps_o (stamps)
  );

  // Stamp of the source being taken, as held before this edge.
  assign take_stamp = (int'(take_src_i) < NUM_SRC) ? stamps[take_src_i] : '0;

  ilh_ring #(
    .NUM_SRC(NUM_SRC), .DEPTH(DEPTH), .TS_W(TS_W),
    .SRC_W(SRC_W), .PTR_W(PTR_W)
  ) u_ring (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take_i),
    .take_src_i  (take_src_i),
    .cycle_i     (cycle_i),
    .raised_ts_i (take_stamp),
    .wr_ptr_o    (wr_ptr),
    .src_o       (ring_src),
    .taken_o     (ring_taken),
    .raised_o    (ring_raised)
  );

  ilh_reader #(
    .DEPTH(DEPTH), .TS_W(TS_W), .SRC_W(SRC_W), .PTR_W(PTR_W)
  ) u_reader (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_ptr_i       (wr_ptr),
    .src_i          (ring_src),
    .taken_i        (ring_taken),
    .raised_i       (ring_raised),
    .rd_req_i       (rd_req_i),
    .rd_idx_i       (rd_idx_i),
    .rd_valid_o     (rd_valid_o),
    .rd_src_o       (rd_src_o),
    .rd_latency_o   (rd_latency_o),
    .rd_gap_valid_o (rd_gap_valid_o),
    .rd_gap_o       (rd_gap_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) total_q <= '0;
    else        total_q <= total_q + CNT_W'(take_i) + CNT_W'(sw_raise_i);
  end

  assign total_o = total_q;

  // R5
  total_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && sw_raise_i) |=> total_o == $past(total_o) + CNT_W'(2));
  // R5
  total_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i ^ sw_raise_i) |=> total_o == $past(total_o) + CNT_W'(1));
  // R5
  total_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_i && !sw_raise_i) |=> $stable(total_o));

endmodule

// File: tb/irq_latency_trace_bench.sv
module irq_latency_trace_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NSRC  = 8;
  localparam int D     = 16;
  localparam int TSW   = 32;
  localparam int CW    = 16;
  localparam int SW    = 3;
  localparam int PW    = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [TSW-1:0]  cycle_i = '0;
  logic [NSRC-1:0] raise_i = '0;
  logic            sw_raise_i = 1'b0;
  logic            take_i = 1'b0;
  logic [SW-1:0]   take_src_i = '0;
  logic            rd_req_i = 1'b0;
  logic [PW-1:0]   rd_idx_i = '0;
  logic            rd_valid_o;
  logic [SW-1:0]   rd_src_o;
  logic [TSW-1:0]  rd_latency_o;
  logic            rd_gap_valid_o;
  logic [TSW-1:0]  rd_gap_o;
  logic [CW-1:0]   total_o;

  irq_latency_trace #(.NUM_SRC(NSRC), .DEPTH(D), .TS_W(TSW), .CNT_W(CW))
  u_irq_latency_trace (
    .clk(clk), .rst_n(rst_n), .cycle_i(cycle_i), .raise_i(raise_i),
    .sw_raise_i(sw_raise_i), .take_i(take_i), .take_src_i(take_src_i),
    .rd_req_i(rd_req_i), .rd_idx_i(rd_idx_i), .rd_valid_o(rd_valid_o),
    .rd_src_o(rd_src_o), .rd_latency_o(rd_latency_o),
    .rd_gap_valid_o(rd_gap_valid_o), .rd_gap_o(rd_gap_o), .total_o(total_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  // Reference model
  logic [TSW-1:0] m_stamp [NSRC];
  logic [SW-1:0]  m_src   [D];
  logic [TSW-1:0] m_taken [D];
  logic [TSW-1:0] m_raised[D];
  int             m_wp;
  logic [CW-1:0]  m_total;

  // Expected read outputs (held between requests)
  logic           e_valid, e_gv;
  logic [SW-1:0]  e_src;
  logic [TSW-1:0] e_lat, e_gap;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int slot_back(input int back);
    return ((m_wp - 1 - back) % D + D) % D;
  endfunction

  task automatic model_read(input int idx);
    logic ok;
    int s, p;
    ok = (idx < D);
    for (int k = 0; k <= idx && k < D; k++)
      if (m_taken[slot_back(k)] == '0) ok = 1'b0;
    s = slot_back(idx);
    p = slot_back((idx > 0) ? idx - 1 : 0);
    e_valid = ok;
    e_src   = ok ? m_src[s] : '0;
    e_lat   = ok ? m_taken[s] - m_raised[s] : '0;
    e_gv    = ok && (idx > 0);
    e_gap   = (ok && idx > 0) ? m_taken[p] - m_taken[s] : '0;
  endtask

  task automatic model_clear();
    for (int i = 0; i < NSRC; i++) m_stamp[i] = '0;
    for (int i = 0; i < D; i++) begin
      m_src[i] = '0; m_taken[i] = '0; m_raised[i] = '0;
    end
    m_wp = 0; m_total = '0;
    e_valid = 1'b0; e_gv = 1'b0; e_src = '0; e_lat = '0; e_gap = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; take_i = 1'b0; raise_i = '0; sw_raise_i = 1'b0;
    rd_req_i = 1'b0; rd_idx_i = '0; cycle_i = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One clock: drive at negedge, model read from old state, then update
  // model, then sample a quarter period after the rising edge.
  task automatic step(input logic tk, input int tid, input logic [NSRC-1:0] rs,
                      input logic sw, input logic rd, input int ridx,
                      input logic [TSW-1:0] cyc);
    @(negedge clk);
    take_i = tk; take_src_i = SW'(tid); raise_i = rs; sw_raise_i = sw;
    rd_req_i = rd; rd_idx_i = PW'(ridx); cycle_i = cyc;
    if (rd) model_read(ridx);
    if (tk) begin
      m_src[m_wp] = SW'(tid);
      m_taken[m_wp] = cyc;
      m_raised[m_wp] = m_stamp[tid];
      m_wp = (m_wp + 1) % D;
    end
    m_total = m_total + CW'(tk) + CW'(sw);
    for (int s = 0; s < NSRC; s++) if (rs[s]) m_stamp[s] = cyc;
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk(rd ? "R7 valid" : "R10 hold valid", 64'(rd_valid_o), 64'(e_valid));
    chk(rd ? "R6 src"   : "R10 hold src",   64'(rd_src_o),   64'(e_src));
    chk(rd ? "R8 latency" : "R10 hold latency", 64'(rd_latency_o), 64'(e_lat));
    chk(rd ? "R9 gap valid" : "R10 hold gap valid", 64'(rd_gap_valid_o), 64'(e_gv));
    chk(rd ? "R9 gap" : "R10 hold gap", 64'(rd_gap_o), 64'(e_gap));
    chk("R5 total", 64'(total_o), 64'(m_total));
  endtask

  task automatic idle(input logic [TSW-1:0] cyc);
    step(1'b0, 0, '0, 1'b0, 1'b0, 0, cyc);
  endtask

  initial begin
    logic [TSW-1:0] cyc;
    void'($urandom(32'd20240607));
    model_clear();
    do_reset();

    // R1: reset state, empty buffer reads invalid
    step(1'b0, 0, '0, 1'b0, 1'b1, 0, 32'd5);
    chk("R1 total after reset", 64'(total_o), 64'd0);
    chk("R1 valid after reset", 64'(rd_valid_o), 64'd0);
    step(1'b0, 0, '0, 1'b0, 1'b1, D-1, 32'd6);
    chk("R1 oldest invalid", 64'(rd_valid_o), 64'd0);

    // R2: two raises of source 5, the later stamp is used
    step(1'b0, 0, 8'h20, 1'b0, 1'b0, 0, 32'd200);
    step(1'b0, 0, 8'h20, 1'b0, 1'b0, 0, 32'd210);
    // R11: take and read in the same cycle sees the empty buffer
    step(1'b1, 5, '0, 1'b0, 1'b1, 0, 32'd215);
    chk("R11 read before write", 64'(rd_valid_o), 64'd0);
    step(1'b0, 0, '0, 1'b0, 1'b1, 0, 32'd216);
    chk("R2 latest stamp latency", 64'(rd_latency_o), 64'd5);
    chk("R3 source recorded", 64'(rd_src_o), 64'd5);

    // R3: raise and take of source 3 together keep the older stamp
    step(1'b0, 0, 8'h08, 1'b0, 1'b0, 0, 32'd300);
    step(1'b1, 3, 8'h08, 1'b0, 1'b0, 0, 32'd320);
    step(1'b0, 0, '0, 1'b0, 1'b1, 0, 32'd321);
    chk("R3 stamp before edge", 64'(rd_latency_o), 64'd20);
    // R9: gap between newest two
    step(1'b0, 0, '0, 1'b0, 1'b1, 1, 32'd322);
    chk("R9 gap second entry", 64'(rd_gap_o), 64'd105);
    // R5: take and software raise together add two
    step(1'b1, 1, '0, 1'b1, 1'b0, 0, 32'd330);
    chk("R5 double increment", 64'(total_o), 64'd4);

    // Random traffic
    cyc = 32'd1000;
    for (int n = 0; n < 1500; n++) begin
      logic [NSRC-1:0] rs;
      rs = NSRC'($urandom & $urandom & $urandom);
      cyc = cyc + 32'd1 + (($urandom % 8 == 0) ? 32'($urandom % 50) : 32'd0);
      step(($urandom % 5) < 2, int'($urandom % NSRC), rs,
           ($urandom % 10) == 0, ($urandom % 5) < 3, int'($urandom % D), cyc);
    end

    // R4: wrap, oldest after DEPTH+3 takes is the 4th take
    do_reset();
    for (int n = 0; n < D + 3; n++)
      step(1'b1, n % NSRC, '0, 1'b0, 1'b0, 0, 32'(100 + 10 * n));
    step(1'b0, 0, '0, 1'b0, 1'b1, D-1, 32'd900);
    chk("R4 oldest after wrap valid", 64'(rd_valid_o), 64'd1);
    chk("R4 oldest after wrap latency", 64'(rd_latency_o), 64'(100 + 10 * 3));
    // R6: index 2 is the third newest take (n = D)
    step(1'b0, 0, '0, 1'b0, 1'b1, 2, 32'd901);
    chk("R6 third newest source", 64'(rd_src_o), 64'(D % NSRC));

    // R7: a take at cycle 0 ends the walk
    step(1'b1, 2, '0, 1'b0, 1'b0, 0, 32'd0);
    step(1'b0, 0, '0, 1'b0, 1'b1, 0, 32'd950);
    chk("R7 zero take invalid", 64'(rd_valid_o), 64'd0);
    step(1'b0, 0, '0, 1'b0, 1'b1, 1, 32'd951);
    chk("R7 walk ended", 64'(rd_valid_o), 64'd0);
    // R10: no request keeps the result
    idle(32'd952);
    chk("R10 hold", 64'(rd_valid_o), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule